// File: doc/BRIEF.md
# Two-Channel Quadrature Pulse Counter

This block counts edges on two pulse inputs into one signed 16-bit count. For each channel, a rising edge and a falling edge can each be set to add one, subtract one or do nothing. Each channel also has a control input. The level of that input can flip the direction the edge selected, so a quadrature encoder's A/B pair can be decoded by wiring each phase to one channel's pulse input and the other phase to its control input. All four inputs first pass through a two-flop synchronizer. An optional glitch filter follows, and it only accepts a new level once that level has persisted for a programmed number of clock cycles.

The running count is watched by five compare points: zero, a high limit, a low limit and two free thresholds. Each compare point has its own enable. The first cycle on which the count equals an enabled compare value produces a one-cycle event, and a source vector shows which compare points caused it. When the count reaches an enabled limit, it returns to zero on the next cycle. A clear input and a hold input give direct control of the count. All configuration comes in on plain input ports.

Top module: `pulse_count_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `count` is 0, `evt` is 0 and `evt_src` is 0.
- R2: Per channel c, mode fields sit at bits [2c+1:2c]. A rise or fall mode code of 1 adds one on that edge and code 2 subtracts one. Codes 0 and 3 leave the count unchanged. When no edge occurs, the count does not move.
- R3: A channel's control mode is taken from `ctl_hi_mode` while its filtered control input is high, and from `ctl_lo_mode` while it is low. Code 1 reverses the direction chosen by the edge mode. Codes 0, 2 and 3 keep that direction.
- R4: When both channels produce a step in the same cycle, the count changes once by their sum: +2, 0 or -2.
- R5: With `flt_en` high and `flt_thresh` = T > 0, a high or low phase on an input is ignored if it lasts fewer than T cycles. A phase of T cycles or more is accepted. With the filter disabled, every synchronized edge is accepted.
- R6: `cnt_clr` high makes `count` 0 on the next cycle, and it takes priority over `cnt_hold`.
- R7: `cnt_hold` high, with `cnt_clr` low, keeps `count` unchanged on the next cycle.
- R8: Compare bits in `cmp_en` and `evt_src` are 0 zero, 1 high limit, 2 low limit, 3 threshold 0 and 4 threshold 1. One cycle after the count first equals an enabled compare value, `evt` pulses for one cycle and the matching `evt_src` bits are set. A disabled compare never sets its bit.
- R9: An event bit does not fire again while the count stays at the compared value.
- R10: With compare bit 1 (or 2) enabled, a count equal to `hi_lim` (or `lo_lim`) becomes 0 on the next cycle, unless clear or hold is high.
- R11: With the filter off, an input edge changes `count` on the fourth rising clock edge after the input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 2 | Pulse input, one per channel |
| ctrl_in | input | 2 | Direction control input, one per channel |
| flt_en | input | 1 | Glitch filter enable |
| flt_thresh | input | 10 | Minimum accepted phase length in cycles |
| rise_mode | input | 4 | Rising-edge mode, 2 bits per channel |
| fall_mode | input | 4 | Falling-edge mode, 2 bits per channel |
| ctl_hi_mode | input | 4 | Control mode while control input is high, 2 bits per channel |
| ctl_lo_mode | input | 4 | Control mode while control input is low, 2 bits per channel |
| cmp_en | input | 5 | Per-compare enables |
| hi_lim | input | 16 | High limit |
| lo_lim | input | 16 | Low limit |
| thr0 | input | 16 | Threshold 0 |
| thr1 | input | 16 | Threshold 1 |
| cnt_clr | input | 1 | Clear count to zero |
| cnt_hold | input | 1 | Freeze count |
| count | output | 16 | Current signed count |
| evt | output | 1 | One-cycle compare event |
| evt_src | output | 5 | Compare points that caused the event |

## Verification
The hardest case to reach is a single cycle in which both channels step at once while the count sits next to an enabled limit. In that case wrap, summing and event detection all interact. The stimulus reaches it by driving both pulse inputs on the same cycle, after first walking the count to a chosen limit with single-channel pulses. Filter boundaries are reached with pulses whose widths are exactly one below the threshold and exactly equal to it. A behavioural model in the bench checks count, event and source on every clock.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam logic [1:0] EDGE_INC = 2'd1;
  localparam logic [1:0] EDGE_DEC = 2'd2;
  localparam logic [1:0] CTL_FLIP = 2'd1;

  localparam int N_CMP    = 5;
  localparam int CMP_ZERO = 0;
  localparam int CMP_HI   = 1;
  localparam int CMP_LO   = 2;
  localparam int CMP_T0   = 3;
  localparam int CMP_T1   = 4;
endpackage

// File: rtl/pcu_cond.sv
module pcu_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int FLT_W       = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic             flt_en,
  input  logic [FLT_W-1:0] flt_thresh,
  output logic             level
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sampled;
  logic [FLT_W-1:0]       run_q;
  logic [FLT_W:0]         run_nx;
  logic                   level_q;
  logic                   bypass;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], din};
  end

  assign sampled = sync_q[SYNC_STAGES-1];
  assign bypass  = !flt_en || (flt_thresh == '0);
  assign run_nx  = {1'b0, run_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b0;
      run_q   <= '0;
    end else if (bypass) begin
      level_q <= sampled;
      run_q   <= '0;
    end else if (sampled == level_q) begin
      run_q   <= '0;
    end else if (run_nx >= {1'b0, flt_thresh}) begin
      level_q <= sampled;
      run_q   <= '0;
    end else begin
      run_q   <= run_nx[FLT_W-1:0];
    end
  end

  assign level = level_q;

  // R5
  filt_follows_input_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(level_q) |-> (level_q == $past(sampled)));
endmodule

// File: rtl/pcu_dir.sv
module pcu_dir
  import pcu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lvl,
  input  logic              ctl_lvl,
  input  logic [1:0]        rise_mode,
  input  logic [1:0]        fall_mode,
  input  logic [1:0]        hi_mode,
  input  logic [1:0]        lo_mode,
  output logic signed [1:0] step
);
  logic              prev_q;
  logic [1:0]        code;
  logic signed [1:0] base;
  logic              flip;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  always_comb begin
    code = 2'd0;
    if (lvl && !prev_q)      code = rise_mode;
    else if (!lvl && prev_q) code = fall_mode;
    case (code)
      EDGE_INC: base = 2'sd1;
      EDGE_DEC: base = -2'sd1;
      default:  base = 2'sd0;
    endcase
    flip = ((ctl_lvl ? hi_mode : lo_mode) == CTL_FLIP);
    step = flip ? -base : base;
  end

  // R2
  quiet_without_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl == prev_q) |-> (step == 2'sd0));
endmodule

// File: rtl/pcu_watch.sv
module pcu_watch
  import pcu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [N_CMP-1:0] cmp_en,
  input  logic [CNT_W-1:0] hi_lim,
  input  logic [CNT_W-1:0] lo_lim,
  input  logic [CNT_W-1:0] thr0,
  input  logic [CNT_W-1:0] thr1,
  output logic             evt,
  output logic [N_CMP-1:0] evt_src
);
  logic [CNT_W-1:0] ref_v [N_CMP];
  logic [N_CMP-1:0] match;
  logic [N_CMP-1:0] hit_q;
  logic [N_CMP-1:0] src_q;
  logic             evt_q;

  always_comb begin
    ref_v[CMP_ZERO] = '0;
    ref_v[CMP_HI]   = hi_lim;
    ref_v[CMP_LO]   = lo_lim;
    ref_v[CMP_T0]   = thr0;
    ref_v[CMP_T1]   = thr1;
  end

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    assign match[k] = cmp_en[k] && (cnt == ref_v[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= '0;
      src_q <= '0;
      evt_q <= 1'b0;
    end else begin
      hit_q <= match;
      src_q <= match & ~hit_q;
      evt_q <= |(match & ~hit_q);
    end
  end

  assign evt     = evt_q;
  assign evt_src = src_q;

  // R9
  no_refire_chk: assert property (@(posedge clk) disable iff (rst)
    ((src_q & $past(src_q)) == '0));
  // R8
  disabled_silent_chk: assert property (@(posedge clk) disable iff (rst)
    ((src_q & ~$past(cmp_en)) == '0));
endmodule

// File: rtl/pulse_count_unit.sv
module pulse_count_unit
  import pcu_pkg::*;
#(
  parameter int N_CH        = 2,
  parameter int CNT_W       = 16,
  parameter int FLT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_CH-1:0]     pulse_in,
  input  logic [N_CH-1:0]     ctrl_in,
  input  logic                flt_en,
  input  logic [FLT_W-1:0]    flt_thresh,
  input  logic [2*N_CH-1:0]   rise_mode,
  input  logic [2*N_CH-1:0]   fall_mode,
  input  logic [2*N_CH-1:0]   ctl_hi_mode,
  input  logic [2*N_CH-1:0]   ctl_lo_mode,
  input  logic [N_CMP-1:0]    cmp_en,
  input  logic [CNT_W-1:0]    hi_lim,
  input  logic [CNT_W-1:0]    lo_lim,
  input  logic [CNT_W-1:0]    thr0,
  input  logic [CNT_W-1:0]    thr1,
  input  logic                cnt_clr,
  input  logic                cnt_hold,
  output logic [CNT_W-1:0]    count,
  output logic                evt,
  output logic [N_CMP-1:0]    evt_src
);
  localparam int N_LINE = 2 * N_CH;

  logic [N_LINE-1:0]  raw;
  logic [N_LINE-1:0]  lvl;
  logic signed [1:0]  step [N_CH];
  logic [CNT_W-1:0]   delta;
  logic [CNT_W-1:0]   count_q;
  logic               at_hi;
  logic               at_lo;

  assign raw = {ctrl_in, pulse_in};

  for (genvar i = 0; i < N_LINE; i++) begin : g_line
    pcu_cond #(.SYNC_STAGES(SYNC_STAGES), .FLT_W(FLT_W)) u_cond (
      .clk(clk), .rst(rst), .din(raw[i]),
      .flt_en(flt_en), .flt_thresh(flt_thresh), .level(lvl[i])
    );
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    pcu_dir u_dir (
      .clk(clk), .rst(rst),
      .lvl(lvl[c]), .ctl_lvl(lvl[N_CH+c]),
      .rise_mode(rise_mode[2*c +: 2]), .fall_mode(fall_mode[2*c +: 2]),
      .hi_mode(ctl_hi_mode[2*c +: 2]), .lo_mode(ctl_lo_mode[2*c +: 2]),
      .step(step[c])
    );
  end

  always_comb begin
    delta = '0;
    for (int c = 0; c < N_CH; c++)
      delta = delta + {{(CNT_W-2){step[c][1]}}, step[c]};
  end

  assign at_hi = cmp_en[CMP_HI] && (count_q == hi_lim);
  assign at_lo = cmp_en[CMP_LO] && (count_q == lo_lim);

  always_ff @(posedge clk) begin
    if (rst)                count_q <= '0;
    else if (cnt_clr)       count_q <= '0;
    else if (cnt_hold)      count_q <= count_q;
    else if (at_hi || at_lo) count_q <= '0;
    else                    count_q <= count_q + delta;
  end

  pcu_watch #(.CNT_W(CNT_W)) u_watch (
    .clk(clk), .rst(rst), .cnt(count_q), .cmp_en(cmp_en),
    .hi_lim(hi_lim), .lo_lim(lo_lim), .thr0(thr0), .thr1(thr1),
    .evt(evt), .evt_src(evt_src)
  );

  assign count = count_q;

  // R6
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (count_q == '0));
  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_hold && !cnt_clr) |=> $stable(count_q));
  // R10
  limit_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!cnt_clr && !cnt_hold && cmp_en[CMP_HI] && (count_q == hi_lim)) |=> (count_q == '0));
  // R4
  step_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (!cnt_clr && !cnt_hold && !at_hi && !at_lo) |=>
      (CNT_W'(count_q - $past(count_q) + CNT_W'(2)) <= CNT_W'(4)));
endmodule

// File: tb/sim_pulse_count_unit.sv
module sim_pulse_count_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  pulse_in = '0, ctrl_in = '0;
  logic        flt_en = 1'b0;
  logic [9:0]  flt_thresh = '0;
  logic [3:0]  rise_mode = '0, fall_mode = '0, ctl_hi_mode = '0, ctl_lo_mode = '0;
  logic [4:0]  cmp_en = '0;
  logic [15:0] hi_lim = 16'd100, lo_lim = 16'hFF9C, thr0 = '0, thr1 = '0;
  logic        cnt_clr = 1'b0, cnt_hold = 1'b0;
  logic [15:0] count;
  logic        evt;
  logic [4:0]  evt_src;

  int checks = 0, fails = 0, cycles = 0;
  int ev_cnt = 0;
  logic [4:0] src_seen = '0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  pulse_count_unit u0 (.*);

  // behavioural reference model
  int m_s1[4], m_s2[4], m_f[4], m_fc[4], m_pv[2], m_hit[5];
  int m_cnt, m_evt, m_src;
  always @(posedge clk) begin
    int lv[4]; int nf[4]; int nfc[4]; int refs[5];
    int d, code, dirn, cm, nxt, nsrc, mk;
    if (rst) begin
      for (int i = 0; i < 4; i++) begin m_s1[i] = 0; m_s2[i] = 0; m_f[i] = 0; m_fc[i] = 0; end
      m_pv[0] = 0; m_pv[1] = 0;
      for (int k = 0; k < 5; k++) m_hit[k] = 0;
      m_cnt = 0; m_evt = 0; m_src = 0;
    end else begin
      lv[0] = pulse_in[0]; lv[1] = pulse_in[1]; lv[2] = ctrl_in[0]; lv[3] = ctrl_in[1];
      for (int i = 0; i < 4; i++) begin
        nf[i] = m_f[i]; nfc[i] = m_fc[i];
        if (!flt_en || flt_thresh == 0) begin nf[i] = m_s2[i]; nfc[i] = 0; end
        else if (m_s2[i] == m_f[i]) nfc[i] = 0;
        else if (m_fc[i] + 1 >= int'(flt_thresh)) begin nf[i] = m_s2[i]; nfc[i] = 0; end
        else nfc[i] = m_fc[i] + 1;
      end
      d = 0;
      for (int c = 0; c < 2; c++) begin
        code = 0;
        if (m_f[c] == 1 && m_pv[c] == 0) code = rise_mode[2*c +: 2];
        else if (m_f[c] == 0 && m_pv[c] == 1) code = fall_mode[2*c +: 2];
        dirn = (code == 1) ? 1 : (code == 2) ? -1 : 0;
        cm = m_f[2+c] ? ctl_hi_mode[2*c +: 2] : ctl_lo_mode[2*c +: 2];
        if (cm == 1) dirn = -dirn;
        d += dirn;
      end
      if (cnt_clr) nxt = 0;
      else if (cnt_hold) nxt = m_cnt;
      else if ((cmp_en[1] && m_cnt == int'(hi_lim)) || (cmp_en[2] && m_cnt == int'(lo_lim))) nxt = 0;
      else nxt = (m_cnt + d + 65536) % 65536;
      refs[0] = 0; refs[1] = hi_lim; refs[2] = lo_lim; refs[3] = thr0; refs[4] = thr1;
      nsrc = 0;
      for (int k = 0; k < 5; k++) begin
        mk = (cmp_en[k] && m_cnt == refs[k]) ? 1 : 0;
        if (mk == 1 && m_hit[k] == 0) nsrc |= (1 << k);
        m_hit[k] = mk;
      end
      m_pv[0] = m_f[0]; m_pv[1] = m_f[1];
      for (int i = 0; i < 4; i++) begin
        m_s2[i] = m_s1[i]; m_s1[i] = lv[i]; m_f[i] = nf[i]; m_fc[i] = nfc[i];
      end
      m_cnt = nxt; m_src = nsrc; m_evt = (nsrc != 0) ? 1 : 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R11 latency is covered here)
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk({cur_req, "/R11 count"}, int'(count), m_cnt);
      chk({cur_req, " evt"}, int'(evt), m_evt);
      chk({cur_req, " evt_src"}, int'(evt_src), m_src);
      if (evt) ev_cnt++;
      src_seen |= evt_src;
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic [1:0] which, input int width, input int gap);
    @(negedge clk); pulse_in = which;
    idle(width);
    pulse_in = 2'b00;
    idle(gap);
  endtask

  initial begin
    idle(3);
    // R1 reset state
    chk("R1 count", int'(count), 0);
    chk("R1 evt", int'(evt), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 count after release", int'(count), 0);
    chk("R1 evt_src after release", int'(evt_src), 0);

    // R2 edge modes on channel 0
    cur_req = "R2";
    rise_mode = 4'b0001;
    for (int i = 0; i < 5; i++) pulse(2'b01, 3, 8);
    chk("R2 rise inc", int'(count), 5);
    rise_mode = 4'b0000; fall_mode = 4'b0010;
    for (int i = 0; i < 2; i++) pulse(2'b01, 3, 8);
    chk("R2 fall dec", int'(count), 3);
    rise_mode = 4'b0011; fall_mode = 4'b0000;
    for (int i = 0; i < 2; i++) pulse(2'b01, 3, 8);
    chk("R2 illegal code", int'(count), 3);

    // R3 control gating
    cur_req = "R3";
    rise_mode = 4'b0001; ctrl_in = 2'b01; ctl_hi_mode = 4'b0001;
    idle(8);
    for (int i = 0; i < 2; i++) pulse(2'b01, 3, 8);
    chk("R3 high flips", int'(count), 1);
    ctl_hi_mode = 4'b0010;
    pulse(2'b01, 3, 8);
    chk("R3 code 2 keeps", int'(count), 2);
    ctrl_in = 2'b00; ctl_hi_mode = 4'b0000; ctl_lo_mode = 4'b0001;
    idle(8);
    pulse(2'b01, 3, 8);
    chk("R3 low flips", int'(count), 1);
    ctl_lo_mode = 4'b0000;

    // R4 both channels in one cycle
    cur_req = "R4";
    rise_mode = 4'b0101;
    for (int i = 0; i < 3; i++) pulse(2'b11, 3, 8);
    chk("R4 sum +2", int'(count), 7);
    rise_mode = 4'b1001;
    pulse(2'b11, 3, 8);
    chk("R4 sum 0", int'(count), 7);
    rise_mode = 4'b1010;
    pulse(2'b11, 3, 8);
    chk("R4 sum -2", int'(count), 5);
    rise_mode = 4'b0001;

    // R5 glitch filter
    cur_req = "R5";
    flt_en = 1'b1; flt_thresh = 10'd5;
    pulse(2'b01, 4, 12);
    chk("R5 narrow rejected", int'(count), 5);
    pulse(2'b01, 5, 12);
    chk("R5 width equal thresh", int'(count), 6);
    pulse(2'b01, 9, 12);
    chk("R5 wide accepted", int'(count), 7);
    flt_en = 1'b0;
    pulse(2'b01, 1, 8);
    chk("R5 filter off", int'(count), 8);

    // R7 hold
    cur_req = "R7";
    cnt_hold = 1'b1;
    for (int i = 0; i < 2; i++) pulse(2'b01, 3, 8);
    chk("R7 held", int'(count), 8);
    cnt_hold = 1'b0;
    pulse(2'b01, 3, 8);
    chk("R7 released", int'(count), 9);

    // R6 clear, also over hold
    cur_req = "R6";
    cnt_clr = 1'b1; @(negedge clk); cnt_clr = 1'b0;
    chk("R6 cleared", int'(count), 0);
    pulse(2'b01, 3, 8);
    cnt_clr = 1'b1; cnt_hold = 1'b1; @(negedge clk); cnt_clr = 1'b0; cnt_hold = 1'b0;
    chk("R6 clear beats hold", int'(count), 0);

    // R8/R9 threshold events
    cur_req = "R8";
    thr0 = 16'd3; thr1 = 16'd4; cmp_en = 5'b01000;
    ev_cnt = 0; src_seen = '0;
    for (int i = 0; i < 3; i++) pulse(2'b01, 3, 8);
    chk("R8 one event", ev_cnt, 1);
    chk("R8 thr0 source", int'(src_seen), 5'b01000);
    cur_req = "R9";
    idle(20);
    chk("R9 no refire", ev_cnt, 1);
    pulse(2'b01, 3, 8);
    chk("R8 disabled thr1 silent", int'(src_seen), 5'b01000);

    // R10 limit wrap
    cur_req = "R10";
    hi_lim = 16'd6; lo_lim = 16'hFFFE; cmp_en = 5'b00111;
    ev_cnt = 0; src_seen = '0;
    pulse(2'b01, 3, 8);
    pulse(2'b01, 3, 8);
    chk("R10 hi wrap", int'(count), 0);
    chk("R10 hi and zero events", int'(src_seen), 5'b00011);
    rise_mode = 4'b0010;
    src_seen = '0;
    pulse(2'b01, 3, 8);
    chk("R10 step below zero", int'(count), 16'hFFFF);
    pulse(2'b01, 3, 8);
    chk("R10 lo wrap", int'(count), 0);
    chk("R10 lo event", int'(src_seen[2]), 1);
    // both channels at once right next to the limit
    rise_mode = 4'b0101; hi_lim = 16'd2;
    pulse(2'b11, 3, 8);
    chk("R10 double step onto limit wraps", int'(count), 0);

    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule